// File: doc/BRIEF.md
# Dual-List ADC Conversion Sequencer

This block is the digital sequencer in front of a successive-approximation converter core. It keeps two conversion lists. The normal list has up to sixteen channel slots, and all of its results go into one shared result register. The priority list has up to four slots, and each slot has its own result register. Each list is started by a one-cycle software pulse or by a rising edge on its own hardware trigger pin. Scan mode walks every slot up to the programmed length. Non-scan mode converts only slot 0. Continuous mode restarts the normal list as soon as a pass ends.

The sequencer times every conversion in ticks of a prescaled converter clock: a programmable sample window plus a fixed encoding window. For the whole of that window it holds a request, with the channel number, towards the core. It takes the core's 12-bit value at the end of the window, once the core acknowledges. A priority trigger that arrives during a normal pass takes over after the conversion in progress. The normal pass then carries on from the slot it had reached.

Four sticky status flags report:
- a completed normal conversion;
- a completed priority pass;
- a normal result overwritten before it was read;
- a value outside a programmed window.

Each flag has an interrupt enable.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A conversion holds `core_req` high for exactly (p+1)*(2*s+28) clock cycles, where p is the `cfg_prescale` code (0..3 selects divide by 2, 4, 6 or 8) and s is `cfg_sample`. The sample time is s+1.5 converter cycles, and encoding adds 12.5 converter cycles. `core_chan` stays stable throughout.
- R2: When `cfg_scan`=1, a pass converts slots 0 to the programmed length, in ascending order. Slot k's channel is bits [5k+4:5k] of the channel vector. When `cfg_scan`=0, a pass converts slot 0 only.
- R3: Each normal-list result appears in `reg_data`, zero-extended from 12 bits. Each normal-list conversion sets `flags[0]` (end of conversion).
- R4: `flags[2]` (overrun) is set when a normal result is stored while the previous one is still unread. A `reg_read` pulse marks the stored result as read.
- R5: Priority slot k stores its zero-extended result in `inj_data[16k+15:16k]`. `flags[1]` is set only when the last slot of a priority pass completes.
- R6: With `cfg_cont`=0, a normal pass stops after its last slot. With `cfg_cont`=1, it restarts at slot 0 until `cfg_cont` is cleared, and then stops at the end of the current pass.
- R7: A hardware trigger starts its list only on a rising edge, and only while its enable is 1. A trigger for a list whose pass is pending or running is ignored.
- R8: A priority trigger during a normal pass runs the priority pass after the current conversion. The normal pass then resumes at its next slot.
- R9: `flags[3]` (window) is set by any conversion whose value is above `awd_high` or below `awd_low`.
- R10: Flags stay set until a 1 is written to the matching `flag_clr` bit; if a set and a clear arrive in the same cycle, the set wins. `irq` is 1 while any flag with its `irq_en` bit set is 1.
- R11: After reset, `flags`, `irq`, `core_req`, `reg_data` and `inj_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_prescale | input | 2 | Converter clock divider code (÷2/4/6/8) |
| cfg_sample | input | 3 | Sample time code s (s+1.5 converter cycles) |
| cfg_scan | input | 1 | 1 = scan all programmed slots |
| cfg_cont | input | 1 | 1 = continuous normal list |
| cfg_reg_len | input | 4 | Last normal slot index |
| cfg_reg_chans | input | 80 | Normal list channels, 5 bits per slot |
| cfg_inj_len | input | 2 | Last priority slot index |
| cfg_inj_chans | input | 20 | Priority list channels, 5 bits per slot |
| cfg_reg_hw_en | input | 1 | Enable hardware trigger, normal list |
| cfg_inj_hw_en | input | 1 | Enable hardware trigger, priority list |
| sw_reg_start | input | 1 | Software start pulse, normal list |
| sw_inj_start | input | 1 | Software start pulse, priority list |
| hw_reg_trig | input | 1 | Hardware trigger pin, normal list |
| hw_inj_trig | input | 1 | Hardware trigger pin, priority list |
| awd_high | input | 12 | Window upper bound |
| awd_low | input | 12 | Window lower bound |
| core_req | output | 1 | Conversion request to the core |
| core_chan | output | 5 | Channel being converted |
| core_ack | input | 1 | Core result valid |
| core_data | input | 12 | Core conversion value |
| reg_read | input | 1 | Pulse: normal result consumed |
| reg_data | output | 16 | Shared normal result |
| inj_data | output | 64 | Four priority results, 16 bits each |
| flag_clr | input | 4 | Write-1-to-clear for flags |
| irq_en | input | 4 | Per-flag interrupt enable |
| flags | output | 4 | {window, overrun, priority done, conversion done} |
| irq | output | 1 | Interrupt request |

## Verification
Conversion length is swept over all four prescaler codes and three sample codes. This separates the divider from the sample counter. Scan passes use a scrambled channel set, so that ordering and slot indexing are both checked. The same lists are then run in non-scan mode, to show that only slot 0 is taken. A priority trigger is injected in the middle of a normal pass, and the recorded channel order shows both the takeover point and the resume slot. Further cases cover:
- hardware triggers that are held high or disabled;
- starts that arrive while a list is busy;
- continuous runs that are stopped partway;
- window bounds that lie inside, above and below the converted value.

// File: rtl/adc_seq_pkg.sv
// Package: shared flag indices for the conversion sequencer.
package adc_seq_pkg;
    localparam int FLAG_EOC  = 0;
    localparam int FLAG_JEOC = 1;
    localparam int FLAG_OVR  = 2;
    localparam int FLAG_AWD  = 3;
    localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/adc_conv_timer.sv
// Conversion timer. It divides the bus clock into converter half-cycles
// ((psel+1) bus clocks each) and counts 2*samp+28 half-cycles, which is
// samp+1.5 sample cycles plus 12.5 encode cycles.
// Assumes psel and samp are held stable while a conversion runs.
module adc_conv_timer #(
    parameter int SAMP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic              hold,
    input  logic [1:0]        psel,
    input  logic [SAMP_W-1:0] samp,
    output logic              last
);
    localparam int HALF_W = (SAMP_W + 3 > 6) ? SAMP_W + 3 : 6;
    localparam logic [HALF_W-1:0] ENC_HALF = HALF_W'(27);

    logic [1:0]        div_cnt;
    logic [HALF_W-1:0] half_cnt;
    logic [HALF_W-1:0] half_last;

    // final half-cycle index of this conversion
    assign half_last = (HALF_W'(samp) << 1) + ENC_HALF;
    assign last      = run && (div_cnt == psel) && (half_cnt == half_last);

    // advance the prescaler and the half-cycle counter; freeze while waiting for the core
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            div_cnt  <= '0;
            half_cnt <= '0;
        end else if (run && !(last && hold)) begin
            if (div_cnt == psel) begin
                div_cnt  <= '0;
                half_cnt <= half_cnt + 1'b1;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assert_div_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (div_cnt <= psel));
endmodule

// File: rtl/adc_flag_bank.sv
// Sticky status flags, each cleared by writing 1; a set wins over a clear in
// the same cycle. The interrupt is the OR of the enabled flags.
module adc_flag_bank #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] en,
    output logic [NF-1:0] flags,
    output logic          irq
);
    // hold each flag until it is cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= set | (flags & ~clr);
    end

    // interrupt from enabled flags
    assign irq = |(flags & en);

    for (genvar k = 0; k < NF; k++) begin : g_chk
        assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            flags[k] && !clr[k] |=> flags[k]);
        assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
            set[k] |=> flags[k]);
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Dual-list conversion sequencer. The normal list has up to REG_SLOTS slots
// and one shared result register; the priority list has up to INJ_SLOTS slots,
// each with its own result register. Priority work is always picked before
// normal work between conversions. Assumes configuration is stable during a pass.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W      = 5,
    parameter int DATA_W    = 12,
    parameter int RES_W     = 16,
    parameter int REG_SLOTS = 16,
    parameter int INJ_SLOTS = 4,
    parameter int SAMP_W    = 3,
    localparam int RIDX_W   = $clog2(REG_SLOTS),
    localparam int IIDX_W   = $clog2(INJ_SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                cfg_prescale,
    input  logic [SAMP_W-1:0]         cfg_sample,
    input  logic                      cfg_scan,
    input  logic                      cfg_cont,
    input  logic [RIDX_W-1:0]         cfg_reg_len,
    input  logic [REG_SLOTS*CH_W-1:0] cfg_reg_chans,
    input  logic [IIDX_W-1:0]         cfg_inj_len,
    input  logic [INJ_SLOTS*CH_W-1:0] cfg_inj_chans,
    input  logic                      cfg_reg_hw_en,
    input  logic                      cfg_inj_hw_en,
    input  logic                      sw_reg_start,
    input  logic                      sw_inj_start,
    input  logic                      hw_reg_trig,
    input  logic                      hw_inj_trig,
    input  logic [DATA_W-1:0]         awd_high,
    input  logic [DATA_W-1:0]         awd_low,
    output logic                      core_req,
    output logic [CH_W-1:0]           core_chan,
    input  logic                      core_ack,
    input  logic [DATA_W-1:0]         core_data,
    input  logic                      reg_read,
    output logic [RES_W-1:0]          reg_data,
    output logic [INJ_SLOTS*RES_W-1:0] inj_data,
    input  logic [NUM_FLAGS-1:0]      flag_clr,
    input  logic [NUM_FLAGS-1:0]      irq_en,
    output logic [NUM_FLAGS-1:0]      flags,
    output logic                      irq
);
    logic              busy, cur_inj;
    logic              reg_active, reg_pend, inj_active, inj_pend;
    logic [RIDX_W-1:0] reg_idx, reg_last;
    logic [IIDX_W-1:0] inj_idx, inj_last;
    logic              hw_reg_q, hw_inj_q;
    logic              reg_trig, inj_trig;
    logic              pick_inj, pick_reg, launch, conv_last, conv_end;
    logic              reg_unread;
    logic [RES_W-1:0]  inj_res [INJ_SLOTS];
    logic [RES_W-1:0]  res_ext;
    logic [NUM_FLAGS-1:0] flag_set;

    // triggers: a software pulse, or a rising edge on an enabled hardware pin
    assign reg_trig = sw_reg_start | (cfg_reg_hw_en & hw_reg_trig & ~hw_reg_q);
    assign inj_trig = sw_inj_start | (cfg_inj_hw_en & hw_inj_trig & ~hw_inj_q);

    // last slot of each pass; non-scan mode uses slot 0 only
    assign reg_last = cfg_scan ? cfg_reg_len : '0;
    assign inj_last = cfg_scan ? cfg_inj_len : '0;

    // choose the next conversion; priority work goes first
    assign pick_inj = inj_active | inj_pend;
    assign pick_reg = ~pick_inj & (reg_active | reg_pend);
    assign launch   = ~busy & (pick_inj | pick_reg);
    assign conv_end = busy & conv_last & core_ack;
    assign res_ext  = {{(RES_W-DATA_W){1'b0}}, core_data};
    assign core_req = busy;

    adc_conv_timer #(.SAMP_W(SAMP_W)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (launch),
        .run   (busy),
        .hold  (~core_ack),
        .psel  (cfg_prescale),
        .samp  (cfg_sample),
        .last  (conv_last)
    );

    // flag events from the completing conversion
    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_EOC]  = conv_end & ~cur_inj;
        flag_set[FLAG_JEOC] = conv_end & cur_inj & (inj_idx == inj_last);
        flag_set[FLAG_OVR]  = conv_end & ~cur_inj & reg_unread;
        flag_set[FLAG_AWD]  = conv_end & ((core_data > awd_high) | (core_data < awd_low));
    end

    adc_flag_bank #(.NF(NUM_FLAGS)) flags_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .en    (irq_en),
        .flags (flags),
        .irq   (irq)
    );

    // list sequencing, conversion launch and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cur_inj    <= 1'b0;
            reg_active <= 1'b0;
            reg_pend   <= 1'b0;
            inj_active <= 1'b0;
            inj_pend   <= 1'b0;
            reg_idx    <= '0;
            inj_idx    <= '0;
            hw_reg_q   <= 1'b0;
            hw_inj_q   <= 1'b0;
            core_chan  <= '0;
            reg_data   <= '0;
            reg_unread <= 1'b0;
            for (int k = 0; k < INJ_SLOTS; k++) inj_res[k] <= '0;
        end else begin
            hw_reg_q <= hw_reg_trig;
            hw_inj_q <= hw_inj_trig;
            if (reg_trig && !reg_active && !reg_pend) reg_pend <= 1'b1;
            if (inj_trig && !inj_active && !inj_pend) inj_pend <= 1'b1;
            if (reg_read) reg_unread <= 1'b0;

            if (launch) begin
                busy    <= 1'b1;
                cur_inj <= pick_inj;
                if (pick_inj) begin
                    if (!inj_active) begin
                        inj_active <= 1'b1;
                        inj_pend   <= 1'b0;
                        inj_idx    <= '0;
                        core_chan  <= cfg_inj_chans[0 +: CH_W];
                    end else begin
                        core_chan  <= cfg_inj_chans[inj_idx*CH_W +: CH_W];
                    end
                end else begin
                    if (!reg_active) begin
                        reg_active <= 1'b1;
                        reg_pend   <= 1'b0;
                        reg_idx    <= '0;
                        core_chan  <= cfg_reg_chans[0 +: CH_W];
                    end else begin
                        core_chan  <= cfg_reg_chans[reg_idx*CH_W +: CH_W];
                    end
                end
            end

            if (conv_end) begin
                busy <= 1'b0;
                if (cur_inj) begin
                    inj_res[inj_idx] <= res_ext;
                    if (inj_idx == inj_last) inj_active <= 1'b0;
                    else                     inj_idx    <= inj_idx + 1'b1;
                end else begin
                    reg_data   <= res_ext;
                    reg_unread <= 1'b1;
                    if (reg_idx == reg_last) begin
                        reg_idx <= '0;
                        if (!cfg_cont) reg_active <= 1'b0;
                    end else begin
                        reg_idx <= reg_idx + 1'b1;
                    end
                end
            end
        end
    end

    for (genvar k = 0; k < INJ_SLOTS; k++) begin : g_inj_out
        assign inj_data[k*RES_W +: RES_W] = inj_res[k];
    end

    assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !conv_end |=> core_req && $stable(core_chan));
    assert_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_end && !cur_inj && reg_unread |=> flags[FLAG_OVR]);
    assert_inj_takeover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_end && inj_pend |=> !core_req ##1 (core_req && cur_inj));
    assert_eoc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_end && !cur_inj |=> flags[FLAG_EOC] && (reg_data == $past(res_ext)));
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_prescale = 2'd0;
    logic [2:0]  cfg_sample = 3'd0;
    logic        cfg_scan = 1'b0, cfg_cont = 1'b0;
    logic [3:0]  cfg_reg_len = 4'd0;
    logic [79:0] cfg_reg_chans = '0;
    logic [1:0]  cfg_inj_len = 2'd0;
    logic [19:0] cfg_inj_chans = '0;
    logic        cfg_reg_hw_en = 1'b0, cfg_inj_hw_en = 1'b0;
    logic        sw_reg_start = 1'b0, sw_inj_start = 1'b0;
    logic        hw_reg_trig = 1'b0, hw_inj_trig = 1'b0;
    logic [11:0] awd_high = 12'hFFF, awd_low = 12'h000;
    logic        core_req;
    logic [4:0]  core_chan;
    logic        core_ack = 1'b1;
    logic [11:0] core_data;
    logic        reg_read = 1'b0;
    logic [15:0] reg_data;
    logic [63:0] inj_data;
    logic [3:0]  flag_clr = 4'd0, irq_en = 4'd0;
    logic [3:0]  flags;
    logic        irq;

    int checks = 0, failures = 0;
    int starts = 0, dones = 0, cur_len = 0;
    logic req_prev = 1'b0;
    int chan_log [64];
    int len_log  [64];
    bit finished = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [11:0] model(input logic [4:0] c);
        return 12'(int'(c) * 97 + 5);
    endfunction

    assign core_data = model(core_chan);

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale), .cfg_sample(cfg_sample),
        .cfg_scan(cfg_scan), .cfg_cont(cfg_cont), .cfg_reg_len(cfg_reg_len),
        .cfg_reg_chans(cfg_reg_chans), .cfg_inj_len(cfg_inj_len), .cfg_inj_chans(cfg_inj_chans),
        .cfg_reg_hw_en(cfg_reg_hw_en), .cfg_inj_hw_en(cfg_inj_hw_en),
        .sw_reg_start(sw_reg_start), .sw_inj_start(sw_inj_start),
        .hw_reg_trig(hw_reg_trig), .hw_inj_trig(hw_inj_trig),
        .awd_high(awd_high), .awd_low(awd_low), .core_req(core_req), .core_chan(core_chan),
        .core_ack(core_ack), .core_data(core_data), .reg_read(reg_read), .reg_data(reg_data),
        .inj_data(inj_data), .flag_clr(flag_clr), .irq_en(irq_en), .flags(flags), .irq(irq)
    );

    // conversion monitor: logs channel and length of each request window
    always @(negedge clk) begin
        if (core_req && !req_prev) begin
            if (starts < 64) chan_log[starts] = int'(core_chan);
            starts++;
            cur_len = 0;
        end
        if (core_req) cur_len++;
        if (!core_req && req_prev) begin
            if (dones < 64) len_log[dones] = cur_len;
            dones++;
        end
        req_prev = core_req;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_log();
        @(negedge clk); #1;
        starts = 0; dones = 0;
    endtask

    task automatic wait_dones(input int n);
        while (dones < n) begin @(negedge clk); #1; end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_reg();
        @(negedge clk); sw_reg_start = 1'b1; @(negedge clk); sw_reg_start = 1'b0;
    endtask

    task automatic pulse_inj();
        @(negedge clk); sw_inj_start = 1'b1; @(negedge clk); sw_inj_start = 1'b0;
    endtask

    task automatic pulse_read_clear();
        @(negedge clk); reg_read = 1'b1; flag_clr = 4'hF;
        @(negedge clk); reg_read = 1'b0; flag_clr = 4'h0;
        #1;
    endtask

    task automatic set_reg_chans(input int c0, input int c1, input int c2, input int c3,
                                 input int c4, input int c5);
        cfg_reg_chans = '0;
        cfg_reg_chans[4:0]   = 5'(c0);
        cfg_reg_chans[9:5]   = 5'(c1);
        cfg_reg_chans[14:10] = 5'(c2);
        cfg_reg_chans[19:15] = 5'(c3);
        cfg_reg_chans[24:20] = 5'(c4);
        cfg_reg_chans[29:25] = 5'(c5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int d;
        repeat (4) @(negedge clk);
        #1;
        // R11: reset state
        chk(flags == 4'd0 && irq == 1'b0 && core_req == 1'b0, "R11 flags/irq/req",
            int'({flags, irq, core_req}), 0);
        chk(reg_data == 16'd0 && inj_data == 64'd0, "R11 results", int'(reg_data), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1/R3: conversion length sweep over prescaler and sample codes
        set_reg_chans(5, 0, 0, 0, 0, 0);
        for (int p = 0; p < 4; p++) begin
            for (int si = 0; si < 3; si++) begin
                int s;
                s = (si == 0) ? 0 : ((si == 1) ? 3 : 7);
                cfg_prescale = 2'(p);
                cfg_sample = 3'(s);
                clr_log();
                pulse_reg();
                wait_dones(1);
                chk(len_log[0] == (p + 1) * (2 * s + 28), "R1 conversion length",
                    len_log[0], (p + 1) * (2 * s + 28));
                chk(reg_data == 16'(model(5)) && flags[0], "R3 result and EOC",
                    int'(reg_data), int'(model(5)));
                chk(flags[2] == 1'b0, "R4 no overrun when read", int'(flags[2]), 0);
                pulse_read_clear();
            end
        end
        cfg_prescale = 2'd0; cfg_sample = 3'd0;

        // R2/R4: scan pass order, overrun without reads
        set_reg_chans(3, 9, 1, 14, 7, 30);
        cfg_scan = 1'b1; cfg_reg_len = 4'd5;
        clr_log();
        pulse_reg();
        wait_dones(6);
        begin
            int exp_c [6] = '{3, 9, 1, 14, 7, 30};
            for (int i = 0; i < 6; i++)
                chk(chan_log[i] == exp_c[i], "R2 scan order", chan_log[i], exp_c[i]);
        end
        chk(reg_data == 16'(model(30)), "R3 last scan result", int'(reg_data), int'(model(30)));
        chk(flags[2] == 1'b1, "R4 overrun set", int'(flags[2]), 1);
        chk(flags[1] == 1'b0, "R5 no JEOC from normal list", int'(flags[1]), 0);
        pulse_read_clear();
        chk(flags == 4'd0, "R10 write-1 clears all", int'(flags), 0);

        // R2: non-scan converts slot 0 only
        cfg_scan = 1'b0;
        clr_log();
        pulse_reg();
        wait_dones(1);
        idle(100);
        chk(dones == 1 && chan_log[0] == 3, "R2 non-scan single slot", dones * 100 + chan_log[0], 103);
        pulse_read_clear();

        // R5: priority scan pass with per-slot results
        cfg_scan = 1'b1; cfg_inj_len = 2'd3;
        cfg_inj_chans = {5'd8, 5'd6, 5'd4, 5'd2};
        clr_log();
        pulse_inj();
        wait_dones(1);
        chk(flags[1] == 1'b0, "R5 JEOC not after first slot", int'(flags[1]), 0);
        wait_dones(4);
        for (int k = 0; k < 4; k++) begin
            chk(inj_data[k*16 +: 16] == 16'(model(5'(2 + 2 * k))), "R5 slot result",
                int'(inj_data[k*16 +: 16]), int'(model(5'(2 + 2 * k))));
        end
        chk(flags[1] == 1'b1 && flags[0] == 1'b0, "R5 JEOC only", int'(flags), 2);
        pulse_read_clear();

        // R5/R2: non-scan priority converts slot 0 only
        cfg_scan = 1'b0;
        cfg_inj_chans = {5'd8, 5'd6, 5'd4, 5'd11};
        clr_log();
        pulse_inj();
        wait_dones(1);
        idle(100);
        chk(dones == 1 && inj_data[15:0] == 16'(model(11)) && inj_data[31:16] == 16'(model(4)),
            "R5 non-scan priority", int'(inj_data[15:0]), int'(model(11)));
        pulse_read_clear();

        // R6: continuous mode then stop
        set_reg_chans(5, 0, 0, 0, 0, 0);
        cfg_cont = 1'b1;
        clr_log();
        pulse_reg();
        wait_dones(3);
        chk(chan_log[0] == 5 && chan_log[1] == 5 && chan_log[2] == 5, "R6 continuous restarts",
            chan_log[2], 5);
        cfg_cont = 1'b0;
        idle(200);
        d = dones;
        idle(200);
        chk(dones == d && core_req == 1'b0, "R6 stops after clearing continuous", dones, d);
        pulse_read_clear();

        // R7: disabled hardware trigger ignored
        clr_log();
        @(negedge clk); hw_reg_trig = 1'b1; @(negedge clk); hw_reg_trig = 1'b0;
        idle(100);
        chk(dones == 0 && starts == 0, "R7 disabled hw trigger", starts, 0);
        // R7: held-high hardware trigger starts exactly one conversion
        cfg_reg_hw_en = 1'b1;
        @(negedge clk); hw_reg_trig = 1'b1;
        idle(150);
        chk(starts == 1 && dones == 1, "R7 edge only", starts, 1);
        @(negedge clk); hw_reg_trig = 1'b0;
        cfg_reg_hw_en = 1'b0;
        pulse_read_clear();
        // R7: start during a running pass ignored
        cfg_scan = 1'b1; cfg_reg_len = 4'd2;
        clr_log();
        pulse_reg();
        while (starts < 2) begin @(negedge clk); #1; end
        pulse_reg();
        wait_dones(3);
        idle(150);
        chk(dones == 3, "R7 busy start ignored", dones, 3);
        pulse_read_clear();

        // R8: priority takeover and resume
        set_reg_chans(10, 11, 12, 13, 0, 0);
        cfg_reg_len = 4'd3; cfg_inj_len = 2'd0;
        cfg_inj_chans = {5'd0, 5'd0, 5'd0, 5'd20};
        clr_log();
        pulse_reg();
        while (starts < 2) begin @(negedge clk); #1; end
        pulse_inj();
        wait_dones(5);
        begin
            int exp_p [5] = '{10, 11, 20, 12, 13};
            for (int i = 0; i < 5; i++)
                chk(chan_log[i] == exp_p[i], "R8 takeover order", chan_log[i], exp_p[i]);
        end
        pulse_read_clear();

        // R9: window flag, inside / above / below (value 490 for channel 5)
        cfg_scan = 1'b0;
        set_reg_chans(5, 0, 0, 0, 0, 0);
        awd_high = 12'd500; awd_low = 12'd400;
        clr_log(); pulse_reg(); wait_dones(1);
        chk(flags[3] == 1'b0, "R9 inside window", int'(flags[3]), 0);
        pulse_read_clear();
        awd_high = 12'd480; awd_low = 12'd0;
        clr_log(); pulse_reg(); wait_dones(1);
        chk(flags[3] == 1'b1, "R9 above high", int'(flags[3]), 1);
        pulse_read_clear();
        awd_high = 12'hFFF; awd_low = 12'd491;
        clr_log(); pulse_reg(); wait_dones(1);
        chk(flags[3] == 1'b1, "R9 below low", int'(flags[3]), 1);

        // R10: selective clear and interrupt enables
        @(negedge clk); flag_clr = 4'b0001; @(negedge clk); flag_clr = 4'b0000; #1;
        chk(flags == 4'b1000, "R10 selective clear", int'(flags), 8);
        irq_en = 4'b1000; #1;
        chk(irq == 1'b1, "R10 irq enabled flag", int'(irq), 1);
        irq_en = 4'b0001; #1;
        chk(irq == 1'b0, "R10 irq masked", int'(irq), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule